// File: doc/BRIEF.md
# Per-Channel Baseline Tracker with Threshold Gate

This block sits behind a multi-channel sampler. Each incoming 12-bit sample carries a channel number and a gain flag (low or high gain). The block keeps one baseline per channel and gain. It estimates that baseline with a first-order exponential moving average, held in 12.8 fixed point. Baselines move only while the block runs in its free-running learning mode. While the block is in triggered compare mode, the stored baselines stay frozen.

In compare mode, every sample is tested against its own channel and gain baseline plus a programmable threshold. Only the samples that rise above that level are forwarded. A forwarded sample carries its channel number, its gain flag and how far it stands above the baseline. For every accepted sample, a one-cycle status pulse reports whether that channel and gain has seen enough learning samples to count as settled.

A small write port sets the filter shift and the threshold.

Top module: `base_track_gate`

## Requirements
- R1: After reset, `fwd_valid` and `stat_valid` are 0. Every channel/gain entry is uninitialised, with a learn count of 0.
- R2: In learn mode (`cmp_mode`=0), the first sample taken by an uninitialised entry loads the baseline with that sample and a zero fraction.
- R3: Each later learn-mode sample S updates baseline B (20 bits, 8 fraction bits) as B := B + ((S·256 − B) >>> k). Here >>> is an arithmetic right shift, so it rounds toward minus infinity.
- R4: A write with `cfg_we`=1 and `cfg_addr`=0 sets k from `cfg_wdata[3:0]`, clamping any value above 10 to 10. A write with `cfg_addr`=1 sets the threshold T from `cfg_wdata[11:0]`. After reset, k=4 and T=0.
- R5: One cycle after each accepted sample, `stat_valid` is 1. `stat_ok` is then 1 exactly when that entry has taken at least 1024 learn-mode samples, counting the current one.
- R6: Compare-mode samples (`cmp_mode`=1) change neither the baseline nor the learn count of any entry.
- R7: A compare-mode sample S is forwarded one cycle later when S > min(floor(B/256) + T, 4095). A forwarded sample sets `fwd_valid`, and `fwd_chan`, `fwd_hg` and `fwd_excess` = S − floor(B/256).
- R8: The sum floor(B/256) + T saturates at 4095; it never wraps. A sample of 4095 is therefore never forwarded when that sum reaches 4095.
- R9: A sample whose channel number is 96 or more is ignored. It gives no status pulse, no forwarding and no state change.
- R10: Low gain (`in_hg`=0) and high gain (`in_hg`=1) of one channel keep independent baselines and counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_mode | input | 1 | 0 = learn baselines, 1 = threshold compare |
| in_valid | input | 1 | Sample strobe |
| in_chan | input | 7 | Channel number of the sample |
| in_hg | input | 1 | Gain flag: 1 = high gain |
| in_data | input | 12 | Sample value |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0 = filter shift, 1 = threshold |
| cfg_wdata | input | 12 | Configuration write data |
| fwd_valid | output | 1 | Forwarded-sample strobe |
| fwd_chan | output | 7 | Channel of the forwarded sample |
| fwd_hg | output | 1 | Gain flag of the forwarded sample |
| fwd_excess | output | 12 | Sample minus integer baseline |
| stat_valid | output | 1 | Status strobe for each accepted sample |
| stat_ok | output | 1 | Entry has settled (at least 1024 learn samples) |

## Verification
The bench targets the 1023rd and 1024th learning samples of a single entry. A design that counts off by one raises `stat_ok` one sample early or late. It checks compare samples placed exactly at the baseline plus threshold and one above it, before and after a burst of large compare-mode samples. A design that keeps learning in compare mode would shift that boundary. A baseline near full scale with a large threshold catches a sum that wraps instead of saturating, because the wrapped sum would forward a full-scale sample. Shift writes above 10, out-of-range channels, and random traffic across both gains are scored against a bench model. That model exposes an unclamped shift, a shared gain entry, or a wrong rounding direction in the filter.

// File: rtl/btg_pkg.sv
package btg_pkg;
   typedef enum logic {
      CFG_SHIFT = 1'b0,
      CFG_THRESH = 1'b1
   } cfg_sel_e;

   localparam int unsigned SHIFT_MAX = 10;

   function automatic logic [3:0] clamp_shift(input logic [3:0] req);
      return (req > 4'(SHIFT_MAX)) ? 4'(SHIFT_MAX) : req;
   endfunction
endpackage

// File: rtl/btg_store.sv
module btg_store #(
   parameter int ENTRIES = 192,
   parameter int BASE_W = 20,
   parameter int CNT_W = 11,
   parameter int CNT_MAX = 1024,
   localparam int IDX_W = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [BASE_W-1:0] rd_base,
   output logic [CNT_W-1:0]  rd_cnt,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [BASE_W-1:0] wr_base,
   input  logic [CNT_W-1:0]  wr_cnt
);
   logic [BASE_W-1:0] base_mem [ENTRIES];
   logic [CNT_W-1:0]  cnt_mem  [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_mem[e] <= '0;
            cnt_mem[e]  <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(e))) begin
            base_mem[e] <= wr_base;
            cnt_mem[e]  <= wr_cnt;
         end
      end
   end

   assign rd_base = base_mem[rd_idx];
   assign rd_cnt  = cnt_mem[rd_idx];

   // R5
   cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_cnt <= CNT_W'(CNT_MAX)));
endmodule

// File: rtl/btg_ema.sv
module btg_ema #(
   parameter int DATA_W = 12,
   parameter int FRAC_W = 8,
   localparam int BASE_W = DATA_W + FRAC_W
) (
   input  logic [DATA_W-1:0] smp_i,
   input  logic [BASE_W-1:0] base_i,
   input  logic              fresh_i,
   input  logic [3:0]        shift_i,
   output logic [BASE_W-1:0] base_o
);
   logic [BASE_W-1:0]      smp_fx;
   logic signed [BASE_W:0] diff;
   logic signed [BASE_W:0] step;

   if (FRAC_W > 0) begin : g_frac
      assign smp_fx = {smp_i, {FRAC_W{1'b0}}};
   end else begin : g_nofrac
      assign smp_fx = smp_i;
   end

   always_comb begin
      diff = $signed({1'b0, smp_fx}) - $signed({1'b0, base_i});
      step = diff >>> shift_i;
      base_o = fresh_i ? smp_fx : base_i + step[BASE_W-1:0];
   end
endmodule

// File: rtl/btg_cmp.sv
module btg_cmp #(
   parameter int DATA_W = 12
) (
   input  logic [DATA_W-1:0] smp_i,
   input  logic [DATA_W-1:0] base_int_i,
   input  logic [DATA_W-1:0] thr_i,
   output logic              pass_o,
   output logic [DATA_W-1:0] excess_o
);
   logic [DATA_W:0]   sum;
   logic [DATA_W-1:0] limit;

   always_comb begin
      sum = {1'b0, base_int_i} + {1'b0, thr_i};
      limit = sum[DATA_W] ? {DATA_W{1'b1}} : sum[DATA_W-1:0];
      pass_o = smp_i > limit;
      excess_o = smp_i - base_int_i;
   end
endmodule

// File: rtl/base_track_gate.sv
module base_track_gate #(
   parameter int NCHAN = 96,
   parameter int DATA_W = 12,
   parameter int FRAC_W = 8,
   parameter int SETTLE = 1024,
   localparam int CHAN_W = $clog2(NCHAN),
   localparam int ENTRIES = 2 * NCHAN,
   localparam int IDX_W = $clog2(ENTRIES),
   localparam int BASE_W = DATA_W + FRAC_W,
   localparam int CNT_W = $clog2(SETTLE + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmp_mode,
   input  logic              in_valid,
   input  logic [CHAN_W-1:0] in_chan,
   input  logic              in_hg,
   input  logic [DATA_W-1:0] in_data,
   input  logic              cfg_we,
   input  logic              cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic              fwd_valid,
   output logic [CHAN_W-1:0] fwd_chan,
   output logic              fwd_hg,
   output logic [DATA_W-1:0] fwd_excess,
   output logic              stat_valid,
   output logic              stat_ok
);
   import btg_pkg::*;

   if (NCHAN < 2) begin : g_bad_chan
      $error("NCHAN must be at least 2");
   end
   if (DATA_W < 4) begin : g_bad_data
      $error("DATA_W must be at least 4");
   end
   if (SETTLE < 1) begin : g_bad_settle
      $error("SETTLE must be at least 1");
   end

   logic [3:0]        shift_q;
   logic [DATA_W-1:0] thr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= 4'd4;
         thr_q   <= '0;
      end else if (cfg_we) begin
         if (cfg_sel_e'(cfg_addr) == CFG_SHIFT) shift_q <= clamp_shift(cfg_wdata[3:0]);
         else                                   thr_q   <= cfg_wdata;
      end
   end

   logic              chan_ok;
   logic [IDX_W-1:0]  idx;
   logic [BASE_W-1:0] cur_base, nxt_base;
   logic [CNT_W-1:0]  cur_cnt, nxt_cnt;
   logic              learn_we;
   logic              pass;
   logic [DATA_W-1:0] excess;

   assign chan_ok  = int'(in_chan) < NCHAN;
   assign idx      = IDX_W'({in_chan, in_hg});
   assign learn_we = in_valid && chan_ok && !cmp_mode;
   assign nxt_cnt  = (cur_cnt == CNT_W'(SETTLE)) ? cur_cnt : cur_cnt + 1'b1;

   btg_store #(.ENTRIES(ENTRIES), .BASE_W(BASE_W), .CNT_W(CNT_W), .CNT_MAX(SETTLE)) u_store (
      .clk(clk), .rst_n(rst_n), .rd_idx(idx), .rd_base(cur_base), .rd_cnt(cur_cnt),
      .wr_en(learn_we), .wr_idx(idx), .wr_base(nxt_base), .wr_cnt(nxt_cnt)
   );

   btg_ema #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_ema (
      .smp_i(in_data), .base_i(cur_base), .fresh_i(cur_cnt == '0),
      .shift_i(shift_q), .base_o(nxt_base)
   );

   btg_cmp #(.DATA_W(DATA_W)) u_cmp (
      .smp_i(in_data), .base_int_i(cur_base[BASE_W-1 -: DATA_W]), .thr_i(thr_q),
      .pass_o(pass), .excess_o(excess)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fwd_valid  <= 1'b0;
         fwd_chan   <= '0;
         fwd_hg     <= 1'b0;
         fwd_excess <= '0;
         stat_valid <= 1'b0;
         stat_ok    <= 1'b0;
      end else begin
         stat_valid <= in_valid && chan_ok;
         fwd_valid  <= in_valid && chan_ok && cmp_mode && pass;
         if (in_valid && chan_ok) begin
            stat_ok    <= (cmp_mode ? cur_cnt : nxt_cnt) >= CNT_W'(SETTLE);
            fwd_chan   <= in_chan;
            fwd_hg     <= in_hg;
            fwd_excess <= excess;
         end
      end
   end

   // R7
   fwd_excess_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> (fwd_excess > $past(thr_q)));
   // R9
   stat_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_valid |-> $past(in_valid));
   // R7
   fwd_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> (stat_valid && $past(cmp_mode)));
   // R4
   shift_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shift_q <= 4'(SHIFT_MAX));
endmodule

// File: tb/base_track_gate_bench.sv
module base_track_gate_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmp_mode = 1'b0, in_valid = 1'b0, in_hg = 1'b0, cfg_we = 1'b0, cfg_addr = 1'b0;
   logic [6:0] in_chan = '0;
   logic [11:0] in_data = '0, cfg_wdata = '0;
   logic fwd_valid, fwd_hg, stat_valid, stat_ok;
   logic [6:0] fwd_chan;
   logic [11:0] fwd_excess;

   int checks = 0, errors = 0;
   int m_base [192];
   int m_cnt [192];
   int m_k = 4, m_thr = 0;

   always #5 clk = ~clk;

   base_track_gate u_base_track_gate (
      .clk(clk), .rst_n(rst_n), .cmp_mode(cmp_mode), .in_valid(in_valid), .in_chan(in_chan),
      .in_hg(in_hg), .in_data(in_data), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .fwd_valid(fwd_valid), .fwd_chan(fwd_chan), .fwd_hg(fwd_hg),
      .fwd_excess(fwd_excess), .stat_valid(stat_valid), .stat_ok(stat_ok)
   );

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cfg(bit addr, int val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = addr; cfg_wdata = 12'(val);
      @(posedge clk); #1;
      cfg_we = 1'b0;
      if (addr) m_thr = val; else m_k = ((val & 15) > 10) ? 10 : (val & 15);
   endtask

   // Expected-value model built from R2, R3, R5..R10.
   task automatic send(int ch, bit hg, int s, string req);
      int idx, bi, lim, diff;
      bit e_stat, e_ok, e_fwd;
      int e_exc;
      @(negedge clk);
      in_valid = 1'b1; in_chan = 7'(ch); in_hg = hg; in_data = 12'(s);
      idx = ch * 2 + int'(hg);
      e_stat = ch < 96; e_fwd = 0; e_ok = 0; e_exc = 0;
      if (e_stat) begin
         if (!cmp_mode) begin
            if (m_cnt[idx] == 0) m_base[idx] = s * 256;
            else begin
               diff = s * 256 - m_base[idx];
               m_base[idx] = m_base[idx] + (diff >>> m_k);
            end
            if (m_cnt[idx] < 1024) m_cnt[idx]++;
         end else begin
            bi = m_base[idx] >> 8;
            lim = (bi + m_thr > 4095) ? 4095 : bi + m_thr;
            e_fwd = s > lim;
            e_exc = s - bi;
         end
         e_ok = m_cnt[idx] >= 1024;
      end
      @(posedge clk); #1;
      in_valid = 1'b0;
      chk(stat_valid == e_stat, {req, " stat_valid"}, int'(stat_valid), int'(e_stat));
      if (e_stat) chk(stat_ok == e_ok, {req, " stat_ok"}, int'(stat_ok), int'(e_ok));
      chk(fwd_valid == e_fwd, {req, " fwd_valid"}, int'(fwd_valid), int'(e_fwd));
      if (e_fwd) begin
         chk(fwd_excess == 12'(e_exc), {req, " fwd_excess"}, int'(fwd_excess), e_exc);
         chk(fwd_chan == 7'(ch) && fwd_hg == hg, {req, " fwd_chan"}, int'(fwd_chan), ch);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < 192; i++) begin m_base[i] = 0; m_cnt[i] = 0; end
      repeat (3) @(posedge clk);
      #1;
      // R1: outputs quiet in reset
      chk(fwd_valid == 0 && stat_valid == 0, "R1 reset outputs", int'(fwd_valid), 0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      chk(fwd_valid == 0 && stat_valid == 0, "R1 after reset", int'(stat_valid), 0);

      // R5: settle boundary on channel 90 low gain (1023 -> not ok, 1024 -> ok)
      for (int i = 0; i < 1024; i++) send(90, 1'b0, 1000 + (i % 7), "R5 settle");

      // R2/R6/R7: k=0 makes the baseline equal the last sample
      cfg(1'b0, 0);
      cfg(1'b1, 20);
      send(10, 1'b0, 500, "R2 first load");
      send(10, 1'b1, 3000, "R10 hg entry");
      cmp_mode = 1'b1;
      send(10, 1'b0, 520, "R7 at limit");
      send(10, 1'b0, 521, "R7 above limit");
      send(10, 1'b1, 3021, "R10 hg compare");
      for (int i = 0; i < 20; i++) send(10, 1'b0, 4000, "R6 burst");
      send(10, 1'b0, 520, "R6 frozen at limit");
      send(10, 1'b0, 521, "R6 frozen above");

      // R8: baseline 4090 plus threshold 20 saturates at 4095
      cmp_mode = 1'b0;
      send(11, 1'b0, 4090, "R8 load");
      cmp_mode = 1'b1;
      send(11, 1'b0, 4095, "R8 saturate");
      // R9: channel out of range
      send(100, 1'b0, 4095, "R9 compare ignore");
      cmp_mode = 1'b0;
      send(127, 1'b1, 0, "R9 learn ignore");

      // R4: shift clamp, then R3 with a slow filter
      cfg(1'b0, 15);
      send(12, 1'b0, 0, "R4 load zero");
      send(12, 1'b0, 4095, "R4 clamped step");
      cfg(1'b1, 0);
      cmp_mode = 1'b1;
      send(12, 1'b0, 4, "R4 clamp visible");

      // R3/R7/R10: random traffic
      for (int r = 0; r < 6; r++) begin
         cmp_mode = 1'b0;
         cfg(1'b0, int'($urandom_range(15)));
         for (int i = 0; i < 1500; i++)
            send(int'($urandom_range(99)), 1'($urandom), int'($urandom_range(4095)), "R3 random learn");
         cmp_mode = 1'b1;
         cfg(1'b1, int'($urandom_range(300)));
         for (int i = 0; i < 800; i++)
            send(int'($urandom_range(99)), 1'($urandom), int'($urandom_range(4095)), "R7 random compare");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule